// File: doc/BRIEF.md
# Memory Reclaim Address Remapper

This block sits at the front of a DRAM controller and sorts every incoming logical request address, up to 8 GB (33 bits), into one of four destinations. Addresses under the low-memory boundary go to DRAM unchanged. Addresses from that boundary up to 4 GB belong to the memory-mapped IO hole. When reclaim is switched on, addresses inside a programmable window above the top of memory are folded back onto the DRAM that the IO hole hides, starting at the low-memory boundary. Anything else at or above the upper-memory top is reported as unmapped.

Four boundaries and an enable bit are set through a small write port that works at 1 MB granularity. A write that would leave reclaim enabled while the low-memory boundary is not 64 MB aligned is refused. The old value stays, and a sticky error flag is raised. With reclaim off, a 1 MB aligned boundary is accepted. Decode results come out one clock after the request, as a registered physical address and a two-bit target code.

Top module: `mem_reclaim_remap`

## Requirements
- R1: A request whose address is below low-boundary×1 MB returns target 2'b00 and a physical address equal to the request address.
- R2: A request at or above the low boundary and below 4 GB returns target 2'b10 (IO) and the request address unchanged.
- R3: With reclaim enabled, a request at or above 4 GB whose 1 MB index lies from the window base through the window limit (limit inclusive, so the window covers up to limit×1 MB + 0xFFFFF) returns target 2'b01 and physical address = address − base×1 MB + low×1 MB, modulo 2^33.
- R4: A request at or above 4 GB that R3 does not claim returns target 2'b11 with the address unchanged if its 1 MB index is at or above the upper top. Otherwise it returns target 2'b00 with the address unchanged.
- R5: With reclaim disabled, no request returns target 2'b01, whatever the window base and limit hold.
- R6: Setting the enable bit is refused when the low boundary has any of its low 6 bits (in 1 MB units) set. Writing such a low boundary while reclaim is enabled is also refused. A refused write leaves the register unchanged and sets cfg_err, which stays set until reset.
- R7: With reclaim disabled, any low-boundary value at 1 MB granularity is accepted and used by the next decode.
- R8: rsp_valid is req_valid delayed by exactly one clock. Synchronous active-high reset clears rsp_valid, rsp_target, rsp_addr, cfg_err, the enable bit and all boundaries to zero.
- R9: cfg_sel codes are 0 low boundary (cfg_wdata[11:0]), 1 upper top, 2 window base, 3 window limit (each cfg_wdata[12:0] in 1 MB units), and 4 control with bit 0 the reclaim enable. Codes 5 to 7 do nothing. A write accepted on one clock applies to a request sampled on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select code |
| cfg_wdata | input | 13 | Write data in 1 MB units |
| cfg_err | output | 1 | Sticky flag for a refused write |
| req_valid | input | 1 | Request address valid |
| req_addr | input | 33 | Logical request address |
| rsp_valid | output | 1 | Decode result valid |
| rsp_addr | output | 33 | Physical address |
| rsp_target | output | 2 | 00 DRAM, 01 remapped DRAM, 10 IO, 11 unmapped |

## Verification
Directed requests are placed one MB step on each side of every boundary: low boundary, 4 GB, window base, window limit and upper top. Each pair tells whether a comparison is strict or inclusive. The same window addresses are sent with reclaim on and then off, which shows that the enable gates the remap and that upper-top classification takes over when it is off. Aligned, unaligned and out-of-order configuration writes test the refusal rule and the sticky flag. Seeded random configurations then send requests biased toward the boundaries, and the bench model predicts the target and the remap arithmetic for each one.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int unsigned PA_W     = 33;  // request address width (8 GB)
  localparam int unsigned MB_LSB   = 20;  // 1 MB granularity
  localparam int unsigned ALIGN_MB = 6;   // 64 MB = 2^6 MB
  localparam int unsigned MB_W     = PA_W - MB_LSB;
  localparam int unsigned LOW_W    = MB_W - 1;

  typedef enum logic [1:0] {
    TGT_DRAM  = 2'b00,
    TGT_REMAP = 2'b01,
    TGT_MMIO  = 2'b10,
    TGT_UNMAP = 2'b11
  } tgt_e;

  typedef enum logic [2:0] {
    SEL_LOW  = 3'd0,
    SEL_UP   = 3'd1,
    SEL_BASE = 3'd2,
    SEL_LIM  = 3'd3,
    SEL_CTRL = 3'd4
  } sel_e;

  // Alignment rule for the low boundary under a given reclaim mode.
  function automatic logic low_ok(input logic en, input logic [LOW_W-1:0] low_mb);
    return !en || (low_mb[ALIGN_MB-1:0] == '0);
  endfunction

  // Fold a window address onto the DRAM behind the IO hole.
  function automatic logic [PA_W-1:0] fold_addr(input logic [PA_W-1:0] addr,
                                                input logic [MB_W-1:0] base_mb,
                                                input logic [LOW_W-1:0] low_mb);
    logic [PA_W-1:0] base_b, low_b;
    base_b = {base_mb, {MB_LSB{1'b0}}};
    low_b  = {1'b0, low_mb, {MB_LSB{1'b0}}};
    return addr - base_b + low_b;
  endfunction
endpackage

// File: rtl/remap_cfg_regs.sv
module remap_cfg_regs
  import remap_pkg::*;
#(
  parameter int unsigned M_W = MB_W,
  parameter int unsigned L_W = LOW_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  logic [2:0]     sel,
  input  logic [M_W-1:0] wdata,
  output logic [L_W-1:0] low_mb,
  output logic [M_W-1:0] up_mb,
  output logic [M_W-1:0] base_mb,
  output logic [M_W-1:0] lim_mb,
  output logic           rcl_en,
  output logic           cfg_err
);
  logic wr_low, wr_ctrl, low_bad, en_bad, wr_reject;

  assign wr_low    = we && (sel == SEL_LOW);
  assign wr_ctrl   = we && (sel == SEL_CTRL);
  assign low_bad   = wr_low && !low_ok(rcl_en, wdata[L_W-1:0]);
  assign en_bad    = wr_ctrl && wdata[0] && !low_ok(1'b1, low_mb);
  assign wr_reject = low_bad || en_bad;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_mb  <= '0;
      up_mb   <= '0;
      base_mb <= '0;
      lim_mb  <= '0;
      rcl_en  <= 1'b0;
      cfg_err <= 1'b0;
    end else begin
      if (wr_reject) cfg_err <= 1'b1;
      if (we && !wr_reject) begin
        case (sel)
          SEL_LOW:  low_mb  <= wdata[L_W-1:0];
          SEL_UP:   up_mb   <= wdata;
          SEL_BASE: base_mb <= wdata;
          SEL_LIM:  lim_mb  <= wdata;
          SEL_CTRL: rcl_en  <= wdata[0];
          default:  ;
        endcase
      end
    end
  end

  // R6: an enabled reclaim never coexists with an unaligned boundary
  p_en_aligned_r6: assert property (@(posedge clk) disable iff (rst)
    rcl_en |-> (low_mb[ALIGN_MB-1:0] == '0));
  // R6: refused write keeps the boundary and the enable
  p_reject_keeps_r6: assert property (@(posedge clk) disable iff (rst)
    wr_reject |=> ($stable(low_mb) && $stable(rcl_en)));
  // R6: error flag is sticky
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> cfg_err);
endmodule

// File: rtl/remap_classify.sv
module remap_classify
  import remap_pkg::*;
#(
  parameter int unsigned A_W = PA_W,
  parameter int unsigned M_W = MB_W,
  parameter int unsigned L_W = LOW_W
) (
  input  logic [A_W-1:0] addr,
  input  logic [L_W-1:0] low_mb,
  input  logic [M_W-1:0] up_mb,
  input  logic [M_W-1:0] base_mb,
  input  logic [M_W-1:0] lim_mb,
  input  logic           rcl_en,
  output tgt_e           tgt,
  output logic [A_W-1:0] phys,
  output logic           below_low,
  output logic           below_4g,
  output logic           in_window,
  output logic           above_up
);
  localparam logic [M_W-1:0] FOUR_G_MB = {1'b1, {L_W{1'b0}}};

  logic [M_W-1:0] addr_mb;
  assign addr_mb   = addr[A_W-1:A_W-M_W];
  assign below_low = addr_mb < {1'b0, low_mb};
  assign below_4g  = addr_mb < FOUR_G_MB;
  assign in_window = rcl_en && (addr_mb >= base_mb) && (addr_mb <= lim_mb);
  assign above_up  = addr_mb >= up_mb;

  always_comb begin
    phys = addr;
    if (below_low)      tgt = TGT_DRAM;
    else if (below_4g)  tgt = TGT_MMIO;
    else if (in_window) begin
      tgt  = TGT_REMAP;
      phys = fold_addr(addr, base_mb, low_mb);
    end
    else if (above_up)  tgt = TGT_UNMAP;
    else                tgt = TGT_DRAM;
  end
endmodule

// File: rtl/mem_reclaim_remap.sv
module mem_reclaim_remap
  import remap_pkg::*;
#(
  parameter int unsigned A_W = PA_W,
  parameter int unsigned M_W = MB_W,
  parameter int unsigned L_W = LOW_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_we,
  input  logic [2:0]     cfg_sel,
  input  logic [M_W-1:0] cfg_wdata,
  output logic           cfg_err,
  input  logic           req_valid,
  input  logic [A_W-1:0] req_addr,
  output logic           rsp_valid,
  output logic [A_W-1:0] rsp_addr,
  output logic [1:0]     rsp_target
);
  localparam logic [M_W-1:0] FOUR_G_MB = {1'b1, {L_W{1'b0}}};

  logic [L_W-1:0] low_mb;
  logic [M_W-1:0] up_mb, base_mb, lim_mb;
  logic           rcl_en;
  tgt_e           cls_tgt;
  logic [A_W-1:0] cls_phys;
  logic           hit_low, hit_4g, hit_win, hit_up;

  remap_cfg_regs #(.M_W(M_W), .L_W(L_W)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .low_mb(low_mb), .up_mb(up_mb), .base_mb(base_mb), .lim_mb(lim_mb),
    .rcl_en(rcl_en), .cfg_err(cfg_err)
  );

  remap_classify #(.A_W(A_W), .M_W(M_W), .L_W(L_W)) u_cls (
    .addr(req_addr), .low_mb(low_mb), .up_mb(up_mb), .base_mb(base_mb),
    .lim_mb(lim_mb), .rcl_en(rcl_en), .tgt(cls_tgt), .phys(cls_phys),
    .below_low(hit_low), .below_4g(hit_4g), .in_window(hit_win), .above_up(hit_up)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_addr   <= '0;
      rsp_target <= TGT_DRAM;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_addr   <= cls_phys;
        rsp_target <= cls_tgt;
      end
    end
  end

  // R8: one-cycle valid latency
  p_lat_hi_r8: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  p_lat_lo_r8: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  // R5: no remap while reclaim is off
  p_no_remap_r5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !rcl_en) |=> (rsp_target != TGT_REMAP));
  // R2: IO results always lie below 4 GB
  p_mmio_low_r2: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_target == TGT_MMIO) |-> (rsp_addr[A_W-1:A_W-M_W] < FOUR_G_MB));
  // R4: unmapped results lie at or above the upper top seen at capture
  p_unmap_high_r4: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_target == TGT_UNMAP) |-> (rsp_addr[A_W-1:A_W-M_W] >= $past(up_mb)));
  // R1: a below-low hit stays DRAM-direct whatever the window says
  p_low_wins_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && hit_low) |=> (rsp_target == TGT_DRAM && rsp_addr == $past(req_addr)));
endmodule

// File: tb/mem_reclaim_remap_tb.sv
module mem_reclaim_remap_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [12:0] cfg_wdata = '0;
  logic        cfg_err;
  logic        req_valid = 1'b0;
  logic [32:0] req_addr = '0;
  logic        rsp_valid;
  logic [32:0] rsp_addr;
  logic [1:0]  rsp_target;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model of the configuration
  logic [11:0] m_low = '0;
  logic [12:0] m_up = '0, m_base = '0, m_lim = '0;
  bit m_en = 0, m_err = 0;

  always #2 clk = ~clk;

  mem_reclaim_remap u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_err(cfg_err), .req_valid(req_valid), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_target(rsp_target)
  );

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_tgt(input logic [32:0] a);
    logic [32:0] lo_b, wb, wt, ub;
    lo_b = 33'(m_low) * 33'h100000;
    wb   = 33'(m_base) * 33'h100000;
    wt   = 33'(m_lim) * 33'h100000 + 33'hFFFFF;
    ub   = 33'(m_up) * 33'h100000;
    if (a < lo_b) return 2'b00;
    if (a < 33'h1_0000_0000) return 2'b10;
    if (m_en && a >= wb && a <= wt) return 2'b01;
    if (a >= ub) return 2'b11;
    return 2'b00;
  endfunction

  function automatic logic [32:0] exp_phys(input logic [32:0] a);
    if (exp_tgt(a) == 2'b01)
      return a + 33'(m_low) * 33'h100000 - 33'(m_base) * 33'h100000;
    return a;
  endfunction

  task automatic wr(input logic [2:0] s, input logic [12:0] d);
    bit ok;
    ok = 1;
    if (s == 3'd0 && m_en && (d[11:0] % 64) != 0) ok = 0;
    if (s == 3'd4 && d[0] && (m_low % 64) != 0) ok = 0;
    if (!ok) m_err = 1;
    else case (s)
      3'd0: m_low = d[11:0];
      3'd1: m_up = d;
      3'd2: m_base = d;
      3'd3: m_lim = d;
      3'd4: m_en = d[0];
      default: ;
    endcase
    @(negedge clk);
    cfg_we = 1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic send(input logic [32:0] a, input string r);
    @(negedge clk);
    req_valid = 1; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    chk({r, " target"}, 64'(rsp_target), 64'(exp_tgt(a)));
    chk({r, " addr"}, 64'(rsp_addr), 64'(exp_phys(a)));
    chk("R8 valid", 64'(rsp_valid), 64'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [32:0] a;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    // R8 reset state
    chk("R8 rsp_valid reset", 64'(rsp_valid), 0);
    chk("R8 rsp_target reset", 64'(rsp_target), 0);
    chk("R8 rsp_addr reset", 64'(rsp_addr), 0);
    chk("R8 cfg_err reset", 64'(cfg_err), 0);
    send(33'h0_4000_0000, "R8 reset decode io");
    @(negedge clk);
    chk("R8 valid drop", 64'(rsp_valid), 0);

    // directed: 2 GB low boundary, 6 GB upper top, window 6..8 GB
    wr(3'd0, 13'h800); wr(3'd1, 13'h1800);
    wr(3'd2, 13'h1800); wr(3'd3, 13'h1FFF);
    wr(3'd4, 13'h1);
    send(33'h0_1234_5678, "R1 low dram");
    send(33'h0_7FFF_FFFF, "R1 last below low");
    send(33'h0_8000_0000, "R2 first io");
    send(33'h0_FFFF_FFFF, "R2 last io");
    send(33'h1_2000_0000, "R4 high dram");
    send(33'h1_7FFF_FFFF, "R4 below up");
    send(33'h1_8000_0000, "R3 window base");
    send(33'h1_FFFF_FFFF, "R3 window limit inclusive");
    chk("R3 fold value", 64'(rsp_addr), 64'h0_FFFF_FFFF);
    wr(3'd3, 13'h1BFF);
    send(33'h1_C000_0000, "R3 R4 past limit unmapped");
    // R6 unaligned low while enabled
    wr(3'd0, 13'h801);
    chk("R6 err set", 64'(cfg_err), 1);
    send(33'h0_8010_0000, "R6 low kept");
    chk("R6 io after reject", 64'(rsp_target), 64'h2);
    // R5 disable reclaim
    wr(3'd4, 13'h0);
    send(33'h1_8000_0000, "R5 window off");
    chk("R5 unmapped when off", 64'(rsp_target), 64'h3);
    // R7 1 MB aligned low accepted, R9 immediate effect
    wr(3'd0, 13'h801);
    send(33'h0_800F_FFFF, "R7 R9 below new low");
    send(33'h0_8010_0000, "R7 at new low");
    wr(3'd4, 13'h1);
    chk("R6 err sticky", 64'(cfg_err), 1);
    send(33'h1_8000_0000, "R6 enable refused");
    wr(3'd5, 13'h1FFF);
    send(33'h0_4000_0000, "R9 unused select");

    // constrained random
    for (int c = 0; c < 25; c++) begin
      wr(3'd4, 13'h0);
      wr(3'd0, ($urandom % 4 == 0) ? 13'($urandom % 4096) : 13'(($urandom % 64) * 64));
      wr(3'd1, 13'h1000 + 13'($urandom % 4096));
      wr(3'd2, 13'h1000 + 13'($urandom % 4096));
      wr(3'd3, m_base + 13'($urandom % 1024));
      wr(3'd4, 13'($urandom % 2));
      if ($urandom % 3 == 0) wr(3'd0, 13'($urandom % 4096));
      for (int k = 0; k < 30; k++) begin
        case ($urandom % 4)
          0: a = {1'($urandom), 32'($urandom)};
          1: a = 33'(m_low) * 33'h100000 + 33'($urandom % 4) - 33'd2;
          2: a = (($urandom % 2) ? 33'(m_base) * 33'h100000 : 33'(m_lim) * 33'h100000 + 33'hFFFFF)
                 + 33'($urandom % 3) - 33'd1;
          default: a = 33'(m_up) * 33'h100000 + 33'($urandom % 4) - 33'd2;
        endcase
        send(a, "R1 R2 R3 R4 random");
      end
      chk("R6 random err", 64'(cfg_err), 64'(m_err));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule